// File: doc/BRIEF.md
# Dual-Frequency Phase Accumulator with Selectable Offsets

This block produces one phase word per clock cycle for a direct digital synthesis chain. A wide accumulator advances each cycle by one of two tuning words, picked by a one-bit frequency select. The block then takes the top bits of the accumulator and adds one of four phase offsets to them. A two-bit offset select picks the offset. The sum is registered and presented as the phase output, together with a valid flag. The phase-to-amplitude conversion and the converter that follow this block are not part of it.

A control block drives the selects and two flags. The clear flag holds the accumulator at zero phase. The sleep flag stops all state from moving, so the accumulator and the output keep their values, and the valid flag drops. Reset is synchronous and active high.

Top module: `phase_acc_dual`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `phase_o` is 0 and `phase_vld_o` is 0, and the accumulator is 0.
- R2: With `freq_sel_i` = 0 the accumulator grows by `freq0_i` at each active edge. With `freq_sel_i` = 1 it grows by `freq1_i`.
- R3: `ofs_sel_i` value n (0 to 3) selects the offset in `ofs_bank_i` bits [12n+11 : 12n].
- R4: The offset is added only to the phase output. The accumulator never holds or accumulates any offset.
- R5: The accumulator wraps modulo 2^32.
- R6: The output is (accumulator bits [31:20] + selected offset) modulo 2^12.
- R7: While `acc_clear_i` is high and `sleep_i` is low, the accumulator is loaded with 0 at each edge, and `phase_o` becomes the selected offset alone (zero phase plus offset).
- R8: While `sleep_i` is high (and `rst` low), the accumulator and `phase_o` keep their values and `phase_vld_o` is 0 after the edge. Changes to selects, words and clear during sleep have no effect.
- R9: An active edge loads `phase_o` from the accumulator value held before that edge, using the selects and offsets applied at that edge. This gives one cycle of latency.
- R10: `phase_vld_o` is 1 after every edge where `rst` and `sleep_i` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| freq0_i | input | 32 | Tuning word 0 |
| freq1_i | input | 32 | Tuning word 1 |
| freq_sel_i | input | 1 | Picks the tuning word |
| ofs_bank_i | input | 48 | Four 12-bit phase offsets, offset n at bits [12n+11:12n] |
| ofs_sel_i | input | 2 | Picks the phase offset |
| acc_clear_i | input | 1 | Holds the accumulator at zero phase |
| sleep_i | input | 1 | Freezes all state and drops valid |
| phase_o | output | 12 | Registered phase word |
| phase_vld_o | output | 1 | Phase word valid |

## Verification
Any input applied before a rising edge shows up in `phase_o` and `phase_vld_o` after that same edge. The accumulator behind those outputs moves at the same edge, so its effect reaches the phase output one edge later. The bench drives inputs on the falling edge and updates its arithmetic model at the rising edge, in the same order the registers update. It compares on the next falling edge, so every comparison matches this one-edge latency. The sweeps cover every pairing of tuning word and offset, runs where the accumulator and the offset sum wrap, clear and sleep intervals with their selects changing, and a reset in the middle of a run.

// File: rtl/phacc_pkg.sv
package phacc_pkg;

    localparam int DEF_ACC_W   = 32;
    localparam int DEF_PH_W    = 12;
    localparam int DEF_NUM_OFS = 4;

    typedef enum logic {
        FWORD_A = 1'b0,
        FWORD_B = 1'b1
    } fword_e;

    typedef struct packed {
        fword_e fsel;
        logic   clear;
        logic   hold;
    } phacc_ctl_t;

    function automatic logic [DEF_ACC_W-1:0] pick_word(
        input fword_e sel,
        input logic [DEF_ACC_W-1:0] w_a,
        input logic [DEF_ACC_W-1:0] w_b
    );
        return (sel == FWORD_B) ? w_b : w_a;
    endfunction

endpackage

// File: rtl/phacc_core.sv
module phacc_core
    import phacc_pkg::*;
#(
    parameter int ACC_W = DEF_ACC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] freq_a,
    input  logic [ACC_W-1:0] freq_b,
    input  phacc_ctl_t       ctl,
    output logic [ACC_W-1:0] acc_q
);

    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] acc_d;

    always_comb begin
        step = (ctl.fsel == FWORD_B) ? freq_b : freq_a;
        if (ctl.clear)
            acc_d = '0;
        else
            acc_d = acc_q + step;
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (!ctl.hold)
            acc_d_load: acc_q <= acc_d;
    end

    // R2
    step_add_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.hold && !ctl.clear) |=>
        (acc_q == $past(acc_q) + ((($past(ctl.fsel)) == FWORD_B) ? $past(freq_b) : $past(freq_a))));

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.clear && !ctl.hold) |=> (acc_q == '0));

    // R8
    sleep_acc_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.hold |=> $stable(acc_q));

endmodule

// File: rtl/phacc_offset.sv
module phacc_offset
    import phacc_pkg::*;
#(
    parameter int ACC_W   = DEF_ACC_W,
    parameter int PH_W    = DEF_PH_W,
    parameter int NUM_OFS = DEF_NUM_OFS,
    localparam int OSEL_W = (NUM_OFS > 1) ? $clog2(NUM_OFS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ACC_W-1:0]        acc_q,
    input  logic [NUM_OFS*PH_W-1:0] bank,
    input  logic [OSEL_W-1:0]       osel,
    input  phacc_ctl_t              ctl,
    output logic [PH_W-1:0]         phase_q,
    output logic                    vld_q
);

    logic [PH_W-1:0] ofs_arr [NUM_OFS];
    logic [PH_W-1:0] ofs_sel;
    logic [PH_W-1:0] top_bits;
    logic [PH_W-1:0] phase_d;

    for (genvar g = 0; g < NUM_OFS; g++) begin : g_unpack
        assign ofs_arr[g] = bank[g*PH_W +: PH_W];
    end

    always_comb begin
        ofs_sel  = ofs_arr[osel];
        top_bits = ctl.clear ? '0 : acc_q[ACC_W-1 -: PH_W];
        phase_d  = top_bits + ofs_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            vld_q   <= 1'b0;
        end else if (ctl.hold) begin
            vld_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            vld_q   <= 1'b1;
        end
    end

    // R1
    reset_out_chk: assert property (@(posedge clk)
        rst |=> (phase_q == '0 && !vld_q));

    // R8
    sleep_out_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.hold |=> ($stable(phase_q) && !vld_q));

    // R10
    vld_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.hold |=> vld_q);

endmodule

// File: rtl/phase_acc_dual.sv
module phase_acc_dual
    import phacc_pkg::*;
#(
    parameter int ACC_W   = DEF_ACC_W,
    parameter int PH_W    = DEF_PH_W,
    parameter int NUM_OFS = DEF_NUM_OFS,
    localparam int OSEL_W = (NUM_OFS > 1) ? $clog2(NUM_OFS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ACC_W-1:0]        freq0_i,
    input  logic [ACC_W-1:0]        freq1_i,
    input  logic                    freq_sel_i,
    input  logic [NUM_OFS*PH_W-1:0] ofs_bank_i,
    input  logic [OSEL_W-1:0]       ofs_sel_i,
    input  logic                    acc_clear_i,
    input  logic                    sleep_i,
    output logic [PH_W-1:0]         phase_o,
    output logic                    phase_vld_o
);

    phacc_ctl_t       ctl;
    logic [ACC_W-1:0] acc_q;

    always_comb begin
        ctl.fsel  = fword_e'(freq_sel_i);
        ctl.clear = acc_clear_i;
        ctl.hold  = sleep_i;
    end

    phacc_core #(
        .ACC_W (ACC_W)
    ) u_core (
        .clk    (clk),
        .rst    (rst),
        .freq_a (freq0_i),
        .freq_b (freq1_i),
        .ctl    (ctl),
        .acc_q  (acc_q)
    );

    phacc_offset #(
        .ACC_W   (ACC_W),
        .PH_W    (PH_W),
        .NUM_OFS (NUM_OFS)
    ) u_offset (
        .clk     (clk),
        .rst     (rst),
        .acc_q   (acc_q),
        .bank    (ofs_bank_i),
        .osel    (ofs_sel_i),
        .ctl     (ctl),
        .phase_q (phase_o),
        .vld_q   (phase_vld_o)
    );

endmodule

// File: tb/test_phase_acc_dual.sv
module test_phase_acc_dual;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] freq0 = '0;
    logic [31:0] freq1 = '0;
    logic        fsel = 1'b0;
    logic [47:0] bank;
    logic [1:0]  osel = '0;
    logic        clr = 1'b0;
    logic        slp = 1'b0;
    logic [11:0] phase;
    logic        vld;

    logic [11:0] ofs [4];
    assign bank = {ofs[3], ofs[2], ofs[1], ofs[0]};

    always #(CLK_P/2) clk = ~clk;

    phase_acc_dual i_phase_acc_dual (
        .clk         (clk),
        .rst         (rst),
        .freq0_i     (freq0),
        .freq1_i     (freq1),
        .freq_sel_i  (fsel),
        .ofs_bank_i  (bank),
        .ofs_sel_i   (osel),
        .acc_clear_i (clr),
        .sleep_i     (slp),
        .phase_o     (phase),
        .phase_vld_o (vld)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    string tag = "R1";

    logic [31:0] m_acc = '0;
    logic [11:0] m_ph  = '0;
    logic        m_vld = 1'b0;

    // model, same order as the registers
    task automatic step();
        logic [31:0] inc;
        @(posedge clk);
        inc = fsel ? freq1 : freq0;
        if (rst) begin
            m_acc = '0; m_ph = '0; m_vld = 1'b0;
        end else if (slp) begin
            m_vld = 1'b0;
        end else begin
            m_ph  = (clr ? 12'h000 : m_acc[31:20]) + ofs[osel];
            m_acc = clr ? 32'h0 : m_acc + inc;
            m_vld = 1'b1;
        end
        @(negedge clk);
        n_cmp++;
        if (phase !== m_ph) begin
            n_bad++;
            $display("FAIL %s phase got %h expected %h", tag, phase, m_ph);
        end
        n_cmp++;
        if (vld !== m_vld) begin
            n_bad++;
            $display("FAIL %s valid got %b expected %b", tag, vld, m_vld);
        end
    endtask

    initial begin
        ofs[0] = 12'h000; ofs[1] = 12'h123; ofs[2] = 12'h800; ofs[3] = 12'hFFF;
        @(negedge clk);
        // R1 reset state
        tag = "R1";
        repeat (3) step();
        rst = 1'b0;
        // R2 R3 R4 R9 R10: sweep every word and offset pairing
        freq0 = 32'h0100_0000;
        freq1 = 32'h0030_0000;
        for (int f = 0; f < 2; f++) begin
            for (int o = 0; o < 4; o++) begin
                fsel = f[0]; osel = o[1:0];
                tag = (o == 0) ? "R2" : "R3";
                repeat (6) step();
            end
        end
        tag = "R4";
        for (int k = 0; k < 16; k++) begin
            osel = k[1:0];
            step();
        end
        // R5 accumulator wrap
        tag = "R5";
        freq0 = 32'hFFFF_FFF7; freq1 = 32'h8000_0001;
        for (int k = 0; k < 24; k++) begin
            fsel = k[2]; osel = k[1:0];
            step();
        end
        // R6 offset sum wrap
        tag = "R6";
        ofs[1] = 12'hF01; ofs[2] = 12'h7FF;
        freq0 = 32'h0F00_0000;
        fsel = 1'b0;
        for (int k = 0; k < 32; k++) begin
            osel = k[1:0];
            step();
        end
        // R7 clear with varying offset
        tag = "R7";
        clr = 1'b1;
        for (int k = 0; k < 8; k++) begin
            osel = k[1:0]; fsel = k[0];
            step();
        end
        clr = 1'b0;
        repeat (4) step();
        // R8 sleep with inputs moving
        tag = "R8";
        slp = 1'b1;
        for (int k = 0; k < 8; k++) begin
            osel = k[1:0]; fsel = ~fsel; clr = k[0];
            freq0 = freq0 + 32'h0123_4567;
            step();
        end
        clr = 1'b0;
        slp = 1'b0;
        // R10 valid back, R9 latency
        tag = "R10";
        repeat (4) step();
        tag = "R9";
        for (int k = 0; k < 12; k++) begin
            osel = k[1:0]; fsel = k[2];
            step();
        end
        // R1 mid-run reset
        tag = "R1";
        rst = 1'b1;
        repeat (2) step();
        rst = 1'b0;
        tag = "R2";
        repeat (6) step();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired got hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule